// File: doc/BRIEF.md
# Reloadable Timer/Event Counter

An 8-bit up-counter that refills itself from a preload register whenever it wraps past all-ones. It has two count sources. In internal mode the source is the core clock divided by a power of two, where the divider is picked by a 3-bit code. In event mode the source is the rising edges of an external input, which are synchronized to the core clock first.

Each wrap drives three outputs:
- a single-cycle overflow strobe;
- a sticky overflow flag that software clears;
- a toggling buzzer output, together with its complement.

A small register bus gives access to the block. A write to the count address sets the preload value. When the counter is stopped, that write also loads the counter. When the counter is running, it changes only the preload, and the new value takes effect at the next wrap. A read of the count address holds back the count tick in that cycle, so the read value cannot tear. The cost is that a tick falling in that cycle is lost.

Top module: `tmr_evt_top`

## Requirements
- R1: After reset the count, preload, control and flag read as 0, and buzz_o=0, buzz_n_o=1.
- R2: With enable=0, a write to address 0 loads wdata_i into both the preload and the count. The count reads back the new value on the next cycle.
- R3: With enable=1, a write to address 0 changes only the preload. The count keeps its sequence until it wraps.
- R4: When a counted tick finds the count at 0xFF, ovf_o is high in that cycle. At that edge the count takes the preload value held before the edge.
- R5: In internal mode, prescaler code n (control bits [2:0]) advances the count once every 2^n clocks. The first advance comes 2^n edges after the edge that set enable. The prescaler phase restarts whenever enable=0.
- R6: In event mode (control bit 3 = 1), each rising edge of evt_i is counted once. The count advances on the third rising clock edge after evt_i rises.
- R7: In a cycle with rd_en_i=1 and addr_i=0, no tick is counted, and a tick due in that cycle is lost.
- R8: Every wrap sets ovf_flag_o. A write to address 2 clears it. A wrap in the same cycle as that write wins.
- R9: buzz_o toggles on every wrap, and buzz_n_o is always its complement.
- R10: Address map: 0 = count (read) / preload (write); 1 = control, with [2:0] prescaler, [3] mode, [4] enable, and upper bits reading 0; 2 = flag in bit 0; 3 reads 0 and ignores writes. rdata_o follows addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (gates counting when addr_i=0) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| evt_i | input | 1 | External event input (asynchronous) |
| ovf_o | output | 1 | Wrap strobe, one cycle |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| buzz_o | output | 1 | Buzzer drive, toggles per wrap |
| buzz_n_o | output | 1 | Complement of buzz_o |

## Verification
The hardest cases to reach are a count read, or a preload write while running, that lands in exactly the cycle the count wraps. A lost tick or a reload that uses the new preload only shows when these events coincide. The stimulus keeps the prescaler codes small and the preloads high so that wraps come often. It then mixes in random reads and writes each cycle, and a cycle-accurate bench model checks every output on every cycle. Directed sequences cover the exact first-tick latency of the prescaler and the event synchronizer.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_CNT = 2'd0,
    SEL_CTL = 2'd1,
    SEL_FLG = 2'd2,
    SEL_RSV = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int unsigned PC_W = (1 << PSC_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (!en_i) pc_q <= '0;
    else            pc_q <= pc_q + 1'b1;
  end

  assign mask   = ~({PC_W{1'b1}} << psc_i);
  assign tick_o = en_i && ((pc_q & mask) == mask);

  // R5
  prescale_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pc_q == '0);
endmodule

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= evt_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R6
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             blk_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, pre_q;
  logic             tick_eff;

  assign tick_eff = en_i & tick_i & ~blk_i;
  assign wrap_o   = tick_eff & (cnt_q == {CNT_W{1'b1}});
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (ld_i) pre_q <= ld_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (ld_i && !en_i)   cnt_q <= ld_val_i;
    else if (tick_eff)        cnt_q <= wrap_o ? pre_q : cnt_q + 1'b1;
  end

  // R2
  stop_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !en_i) |=> cnt_q == $past(ld_val_i));
  // R3
  run_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && en_i && !tick_i) |=> cnt_q == $past(cnt_q));
  // R4
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == $past(pre_q));
  // R7
  read_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && blk_i) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PSC_W   = 3,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              evt_i,
  output logic              ovf_o,
  output logic              ovf_flag_o,
  output logic              buzz_o,
  output logic              buzz_n_o
);
  localparam int unsigned MODE_B = PSC_W;
  localparam int unsigned EN_B   = PSC_W + 1;
  localparam int unsigned CTL_W  = PSC_W + 2;

  reg_sel_e         sel;
  logic [CTL_W-1:0] ctl_q;
  logic             flag_q, buzz_q;
  logic             psc_tick, evt_rise, src_tick, wrap;
  logic [CNT_W-1:0] cnt;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctl_q <= '0;
    else if (wr_en_i && sel == SEL_CTL)   ctl_q <= wdata_i[CTL_W-1:0];
  end

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctl_q[EN_B]),
    .psc_i (ctl_q[PSC_W-1:0]),
    .tick_o(psc_tick)
  );

  tmr_evt_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .rise_o(evt_rise)
  );

  assign src_tick = ctl_q[MODE_B] ? evt_rise : psc_tick;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctl_q[EN_B]),
    .tick_i  (src_tick),
    .blk_i   (rd_en_i && sel == SEL_CNT),
    .ld_i    (wr_en_i && sel == SEL_CNT),
    .ld_val_i(wdata_i),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= 1'b0;
    else if (wrap)                      flag_q <= 1'b1;
    else if (wr_en_i && sel == SEL_FLG) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   buzz_q <= 1'b0;
    else if (wrap) buzz_q <= ~buzz_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CNT: rdata_o = cnt;
      SEL_CTL: rdata_o = CNT_W'(ctl_q);
      SEL_FLG: rdata_o = CNT_W'(flag_q);
      default: rdata_o = '0;
    endcase
  end

  assign ovf_o      = wrap;
  assign ovf_flag_o = flag_q;
  assign buzz_o     = buzz_q;
  assign buzz_n_o   = ~buzz_q;

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_flag_o);
  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !(wr_en_i && sel == SEL_FLG)) |=> ovf_flag_o);
  // R9
  buzz_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> buzz_o != $past(buzz_o));
  // R9
  buzz_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |=> buzz_o == $past(buzz_o));
endmodule

// File: tb/sim_tmr_evt_top.sv
module sim_tmr_evt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, evt = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf, flag, buzz, buzz_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_cnt = '0, m_pre = '0;
  logic [2:0] m_psc = '0;
  logic       m_mode = 1'b0, m_en = 1'b0, m_flag = 1'b0, m_buzz = 1'b0;
  logic [6:0] m_pc = '0;
  logic       s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;

  always #2 clk = ~clk;

  tmr_evt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
    .ovf_o(ovf), .ovf_flag_o(flag), .buzz_o(buzz), .buzz_n_o(buzz_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] f_mask(input logic [2:0] n);
    return 7'((8'd1 << n) - 1);
  endfunction

  function automatic logic f_tick(input logic rd, input logic [1:0] a);
    logic src;
    src = m_mode ? (s2 & ~s3) : ((m_pc & f_mask(m_psc)) == f_mask(m_psc));
    return m_en & src & ~(rd && a == 2'd0);
  endfunction

  function automatic logic [7:0] f_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return {3'b0, m_en, m_mode, m_psc};
      2'd2:    return {7'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  // one bus cycle: drive after negedge, check, advance model at posedge
  task automatic cyc(input string tag, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [7:0] d, input logic e);
    logic tk, wp;
    wr_en = wr; rd_en = rd; addr = a; wdata = d; evt = e;
    #1;
    tk = f_tick(rd, a);
    wp = tk && (m_cnt == 8'hFF);
    chk(tag, rdata, f_rdata(a));
    chk("R4", ovf, wp);
    chk("R8", flag, m_flag);
    chk("R9", {buzz, buzz_n}, {m_buzz, ~m_buzz});
    @(posedge clk);
    if (wr && a == 2'd0 && !m_en) m_cnt = d;
    else if (tk)                  m_cnt = wp ? m_pre : m_cnt + 8'd1;
    if (wr && a == 2'd0) m_pre = d;
    m_pc = m_en ? m_pc + 7'd1 : 7'd0;
    if (wr && a == 2'd1) {m_en, m_mode, m_psc} = d[4:0];
    if (wp)                       m_flag = 1'b1;
    else if (wr && a == 2'd2)     m_flag = 1'b0;
    if (wp) m_buzz = ~m_buzz;
    s3 = s2; s2 = s1; s1 = e;
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, a, 8'h00, evt);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state on every address
    for (int a = 0; a < 4; a++) cyc("R1", 1'b0, 1'b0, 2'(a), 8'h00, 1'b0);
    chk("R1", {rdata, buzz, buzz_n, flag}, {8'h00, 1'b0, 1'b1, 1'b0});

    // R2 stopped write loads count
    cyc("R2", 1'b1, 1'b0, 2'd0, 8'hFC, 1'b0);
    cyc("R2", 1'b0, 1'b1, 2'd0, 8'h00, 1'b0);
    chk("R2", rdata, 8'hFC);

    // R5 code 2: first advance 4 edges after enable
    cyc("R10", 1'b1, 1'b0, 2'd1, 8'h12, 1'b0);
    idle("R5", 3, 2'd0);
    chk("R5", rdata, 8'hFC);
    idle("R5", 1, 2'd0);
    chk("R5", rdata, 8'hFD);
    idle("R5", 8, 2'd0);
    chk("R5", rdata, 8'hFF);

    // R3 running write changes only preload; R4 reload at wrap
    cyc("R3", 1'b1, 1'b0, 2'd0, 8'h40, 1'b0);
    chk("R3", rdata, 8'hFF);
    idle("R4", 4, 2'd0);
    chk("R4", rdata, 8'h40);
    chk("R8", flag, 1'b1);

    // R8 clear; R10 reserved address reads zero, ignores writes
    cyc("R8", 1'b1, 1'b0, 2'd2, 8'hFF, 1'b0);
    cyc("R8", 1'b0, 1'b0, 2'd2, 8'h00, 1'b0);
    chk("R8", rdata, 8'h00);
    cyc("R10", 1'b1, 1'b0, 2'd3, 8'hAA, 1'b0);
    cyc("R10", 1'b0, 1'b0, 2'd3, 8'h00, 1'b0);
    chk("R10", rdata, 8'h00);

    // R7 reads at code 0 block every tick
    cyc("R10", 1'b1, 1'b0, 2'd1, 8'h10, 1'b0);
    c0 = rdata;
    for (int i = 0; i < 5; i++) cyc("R7", 1'b0, 1'b1, 2'd0, 8'h00, 1'b0);
    chk("R7", rdata, m_cnt);

    // R6 event mode: stop, load, enable event mode
    cyc("R10", 1'b1, 1'b0, 2'd1, 8'h00, 1'b0);
    cyc("R6", 1'b1, 1'b0, 2'd0, 8'h10, 1'b0);
    cyc("R10", 1'b1, 1'b0, 2'd1, 8'h18, 1'b0);
    cyc("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    cyc("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    chk("R6", rdata, 8'h10);
    cyc("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    chk("R6", rdata, 8'h11);
    for (int i = 0; i < 6; i++) cyc("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    chk("R6", rdata, 8'h11);
    for (int i = 0; i < 40; i++) cyc("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'(i % 3 == 0));

    // random mix with fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic wr, rd;
      logic [1:0] a;
      logic [7:0] d;
      r  = $urandom;
      wr = (r[3:0] == 4'd0);
      rd = (r[7:4] < 4'd3);
      a  = r[9:8];
      d  = 8'($urandom);
      if (wr && a == 2'd1) d = {3'b000, ~(r[12:10] == 3'd0), r[13], 1'b0, r[15:14]};
      if (wr && a == 2'd0) d = d | 8'hE0;
      cyc(a == 2'd0 ? "R3" : "R10", wr, rd, a, d, r[20]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule